// File: doc/BRIEF.md
# EEPROM Write-Protection Flag Controller

This block sits between a serial EEPROM's bus front end and its memory array. For every write the front end wants to commit, it decides whether the write may go ahead. The decision depends on three things: the level of the hardware protect pin, the target address, and two software protect flags. One flag is permanent and the other is reversible. The permit output is combinational, so it is valid in the same cycle in which the front end presents the address.

The front end decodes the flag commands and hands them over as single-cycle strobes. The permanent flag can only be set; after that, only a reset clears it. The reversible flag can be set and cleared. Either action is accepted only while a high voltage is detected on the first address pin and the other two address pins sit at their required levels. While the protect pin is high, every flag command is refused and a one-cycle reject pulse follows.

The block also supplies the status byte that the front end returns when a read uses the alternate device-type code. That byte carries the two flags inverted. The flags are held in registers whose reset value stands in for the unprotected factory state.

Top module: `eeprom_guard`

## Requirements
- R1: After reset both flags are clear, `flag_status` reads 0x03 and `cmd_reject` is 0.
- R2: While `wp_pin` is 1, `allow_write` is 0 for every address in the same cycle.
- R3: While `wp_pin` is 0 and neither flag is set, `allow_write` is 1 for every address.
- R4: While `wp_pin` is 0 and at least one flag is set, `allow_write` is 0 for addresses 0x00 to 0x7F and 1 for addresses 0x80 to 0xFF, in the same cycle.
- R5: A `perm_set` strobe with `wp_pin` 0 sets the permanent flag at the next clock edge. No input other than reset clears it.
- R6: `rev_set` and `rev_clr` change the reversible flag at the next edge, but only when `wp_pin` is 0, `a0_hv` is 1, `a1_lvl` is 0 and `a2_lvl` is 0. Otherwise the flag keeps its value. If both strobes arrive together, the set wins.
- R7: `flag_status` is {6'b0, ~permanent, ~reversible}: bit 1 is the inverted permanent flag and bit 0 is the inverted reversible flag. It reflects a flag change from the cycle after the accepting edge.
- R8: Any of `perm_set`, `rev_set` or `rev_clr` sampled while `wp_pin` is 1 leaves both flags unchanged. It also makes `cmd_reject` 1 for exactly the cycle after that edge. No other condition raises `cmd_reject`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears both flags |
| wp_pin | input | 1 | Hardware protect pin level (1 = protect everything) |
| wr_addr | input | 8 | Byte address of the write being committed |
| perm_set | input | 1 | Strobe: set the permanent flag |
| rev_set | input | 1 | Strobe: set the reversible flag |
| rev_clr | input | 1 | Strobe: clear the reversible flag |
| a0_hv | input | 1 | High-voltage detect on address pin 0 |
| a1_lvl | input | 1 | Logic level of address pin 1 |
| a2_lvl | input | 1 | Logic level of address pin 2 |
| allow_write | output | 1 | Combinational permit for the current write |
| flag_status | output | 8 | Status byte for the alternate-code read |
| cmd_reject | output | 1 | One-cycle pulse after a refused flag command |

## Verification
`allow_write` is due in the same cycle as its inputs. The bench therefore drives inputs just after a falling edge and checks it one nanosecond later, against the flags held before the coming rising edge. Flag commands take effect at that rising edge. Both `flag_status` and `cmd_reject` are checked one nanosecond after the edge, once the bench has updated its own flag model with the same edge.

// File: rtl/eeprom_guard_pkg.sv
package eeprom_guard_pkg;

  // Address falls in the lower (software-protectable) half of a 2**aw space.
  function automatic logic in_low_half(input logic [15:0] addr, input int unsigned aw);
    logic [16:0] half;
    half = 17'd1 << (aw - 1);
    return ({1'b0, addr} < half);
  endfunction

  // Pin qualifier for reversible-flag commands.
  function automatic logic hv_qualified(input logic hv, input logic p1, input logic p2,
                                        input logic p1_req, input logic p2_req);
    return hv && (p1 == p1_req) && (p2 == p2_req);
  endfunction

  // Status byte: inverted flags in the two lowest bits, zeros above.
  function automatic logic [7:0] status_pack(input logic perm, input logic rev);
    return {6'b000000, ~perm, ~rev};
  endfunction

endpackage

// File: rtl/guard_flags.sv
module guard_flags
  import eeprom_guard_pkg::*;
#(
  parameter logic A1_REQ = 1'b0,
  parameter logic A2_REQ = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_pin,
  input  logic perm_set,
  input  logic rev_set,
  input  logic rev_clr,
  input  logic a0_hv,
  input  logic a1_lvl,
  input  logic a2_lvl,
  output logic perm_q,
  output logic rev_q,
  output logic reject_q
);

  logic rev_ok;
  logic any_cmd;
  logic perm_d;
  logic rev_d;

  assign rev_ok  = !wp_pin && hv_qualified(a0_hv, a1_lvl, a2_lvl, A1_REQ, A2_REQ);
  assign any_cmd = perm_set || rev_set || rev_clr;

  always_comb begin
    perm_d = perm_q || (perm_set && !wp_pin);
    rev_d  = rev_q;
    if (rev_ok) begin
      if (rev_set)      rev_d = 1'b1;
      else if (rev_clr) rev_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q   <= 1'b0;
      rev_q    <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      perm_q   <= perm_d;
      rev_q    <= rev_d;
      reject_q <= wp_pin && any_cmd;
    end
  end

  // R5: permanent flag never falls once set
  p_perm_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    perm_q |=> perm_q);

  // R6: reversible flag only moves under the high-voltage qualifier
  p_rev_needs_hv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_q != $past(rev_q)) |-> $past(!wp_pin && a0_hv && a1_lvl == A1_REQ && a2_lvl == A2_REQ));

  // R8: protect pin freezes both flags
  p_wp_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_pin |=> $stable({perm_q, rev_q}));

  // R8: reject only follows a command seen under the protect pin
  p_reject_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject_q |-> $past(wp_pin && (perm_set || rev_set || rev_clr)));

endmodule

// File: rtl/guard_gate.sv
module guard_gate
  import eeprom_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wp_pin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              perm_q,
  input  logic              rev_q,
  output logic              allow_write
);

  logic low_half;
  logic sw_block;

  assign low_half    = in_low_half(16'(wr_addr), ADDR_W);
  assign sw_block    = low_half && (perm_q || rev_q);
  assign allow_write = !wp_pin && !sw_block;

  // R2: protect pin overrides everything
  always_comb begin
    if (wp_pin) p_wp_blocks_r2: assert (!allow_write);
  end

  // R4: upper half never blocked by software flags
  always_comb begin
    if (!wp_pin && !low_half) p_upper_free_r4: assert (allow_write);
  end

endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard
  import eeprom_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic        A1_REQ = 1'b0,
  parameter logic        A2_REQ = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              perm_set,
  input  logic              rev_set,
  input  logic              rev_clr,
  input  logic              a0_hv,
  input  logic              a1_lvl,
  input  logic              a2_lvl,
  output logic              allow_write,
  output logic [7:0]        flag_status,
  output logic              cmd_reject
);

  logic perm_q;
  logic rev_q;

  guard_flags #(
    .A1_REQ (A1_REQ),
    .A2_REQ (A2_REQ)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_pin   (wp_pin),
    .perm_set (perm_set),
    .rev_set  (rev_set),
    .rev_clr  (rev_clr),
    .a0_hv    (a0_hv),
    .a1_lvl   (a1_lvl),
    .a2_lvl   (a2_lvl),
    .perm_q   (perm_q),
    .rev_q    (rev_q),
    .reject_q (cmd_reject)
  );

  guard_gate #(
    .ADDR_W (ADDR_W)
  ) u_gate (
    .wp_pin      (wp_pin),
    .wr_addr     (wr_addr),
    .perm_q      (perm_q),
    .rev_q       (rev_q),
    .allow_write (allow_write)
  );

  assign flag_status = status_pack(perm_q, rev_q);

  // R7: a permitted low-half write implies both status bits read unprotected
  p_status_low_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_write && (wr_addr < ADDR_W'(1 << (ADDR_W - 1)))) |-> (flag_status[1:0] == 2'b11));

  // R7: upper status bits are never driven
  p_status_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_reject || !cmd_reject) |-> (flag_status[7:2] == 6'd0));

endmodule

// File: tb/test_eeprom_guard.sv
module test_eeprom_guard;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp_pin = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic       perm_set = 1'b0, rev_set = 1'b0, rev_clr = 1'b0;
  logic       a0_hv = 1'b0, a1_lvl = 1'b0, a2_lvl = 1'b0;
  logic       allow_write;
  logic [7:0] flag_status;
  logic       cmd_reject;

  int n_checks = 0;
  int n_fail   = 0;
  logic m_perm = 1'b0;
  logic m_rev  = 1'b0;
  logic exp_rej = 1'b0;

  always #5 clk = ~clk;

  eeprom_guard i_eeprom_guard (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .wr_addr(wr_addr),
    .perm_set(perm_set), .rev_set(rev_set), .rev_clr(rev_clr),
    .a0_hv(a0_hv), .a1_lvl(a1_lvl), .a2_lvl(a2_lvl),
    .allow_write(allow_write), .flag_status(flag_status), .cmd_reject(cmd_reject)
  );

  function automatic logic exp_allow(logic wp, logic [7:0] a, logic p, logic r);
    if (wp) return 1'b0;
    if (a[7]) return 1'b1;
    return !(p | r);
  endfunction

  function automatic logic [7:0] exp_status(logic p, logic r);
    logic [7:0] s;
    s = 8'h00;
    s[1] = !p;
    s[0] = !r;
    return s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, check the comb permit, advance, check registered results.
  task automatic step(logic wp, logic [7:0] a, logic ps, logic rs, logic rc,
                      logic hv, logic l1, logic l2);
    logic ok;
    @(negedge clk);
    wp_pin = wp; wr_addr = a; perm_set = ps; rev_set = rs; rev_clr = rc;
    a0_hv = hv; a1_lvl = l1; a2_lvl = l2;
    #1;
    if (wp) check("R2", 32'(allow_write), 32'(exp_allow(wp, a, m_perm, m_rev)));
    else if (m_perm | m_rev) check("R4", 32'(allow_write), 32'(exp_allow(wp, a, m_perm, m_rev)));
    else check("R3", 32'(allow_write), 32'(exp_allow(wp, a, m_perm, m_rev)));
    check("R7", 32'(flag_status), 32'(exp_status(m_perm, m_rev)));
    // model update
    exp_rej = wp && (ps || rs || rc);
    if (!wp && ps) m_perm = 1'b1;
    ok = !wp && hv && !l1 && !l2;
    if (ok && rs) m_rev = 1'b1;
    else if (ok && rc) m_rev = 1'b0;
    @(posedge clk);
    #1;
    check("R8", 32'(cmd_reject), 32'(exp_rej));
    check("R5", 32'(i_flags_perm_visible()), 32'(m_perm));
    check("R6", 32'(flag_status[0]), 32'(!m_rev));
  endtask

  function automatic logic i_flags_perm_visible();
    return !flag_status[1];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h0000_5eed));
    #12;
    check("R1", 32'(flag_status), 32'h03);
    check("R1", 32'(cmd_reject), 32'h0);
    rst_n = 1'b1;
    // R1/R3: unprotected after reset, both halves writable
    step(0, 8'h00, 0, 0, 0, 0, 0, 0);
    step(0, 8'hFF, 0, 0, 0, 0, 0, 0);
    // R2: protect pin blocks upper half too
    step(1, 8'hC0, 0, 0, 0, 0, 0, 0);
    // R6: reversible set without high voltage ignored
    step(0, 8'h10, 0, 1, 0, 0, 0, 0);
    // R6: wrong pin level ignored
    step(0, 8'h10, 0, 1, 0, 1, 1, 0);
    // R6: qualified set
    step(0, 8'h10, 0, 1, 0, 1, 0, 0);
    // R4: boundary 0x7F blocked, 0x80 free
    step(0, 8'h7F, 0, 0, 0, 0, 0, 0);
    step(0, 8'h80, 0, 0, 0, 0, 0, 0);
    // R6: clear without qualifier ignored, then qualified clear
    step(0, 8'h00, 0, 0, 1, 0, 0, 0);
    step(0, 8'h00, 0, 0, 1, 1, 0, 0);
    // R6: set and clear together -> set wins
    step(0, 8'h00, 0, 1, 1, 1, 0, 0);
    step(0, 8'h00, 0, 0, 1, 1, 0, 0);
    // R8: commands under protect pin rejected, flags frozen
    step(1, 8'h00, 1, 1, 0, 1, 0, 0);
    step(0, 8'h00, 0, 0, 0, 0, 0, 0);
    // R5: permanent set, then try every clearing path
    step(0, 8'h20, 1, 0, 0, 0, 0, 0);
    step(0, 8'h20, 0, 0, 1, 1, 0, 0);
    step(0, 8'h7F, 0, 0, 0, 0, 0, 0);
    step(0, 8'h80, 0, 0, 0, 0, 0, 0);
    // reset back, then constrained random
    @(negedge clk);
    rst_n = 1'b0;
    m_perm = 1'b0; m_rev = 1'b0;
    #1;
    check("R1", 32'(flag_status), 32'h03);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic r_wp, r_ps, r_rs, r_rc, r_hv, r_l1, r_l2;
      a    = 8'($urandom);
      r_wp = ($urandom % 4) == 0;
      r_ps = ($urandom % 40) == 0;
      r_rs = ($urandom % 6) == 0;
      r_rc = ($urandom % 5) == 0;
      r_hv = ($urandom % 3) != 0;
      r_l1 = ($urandom % 5) == 0;
      r_l2 = ($urandom % 5) == 0;
      step(r_wp, a, r_ps, r_rs, r_rc, r_hv, r_l1, r_l2);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule